// File: doc/BRIEF.md
# Halfword and Signed Load/Store Formatter

This block sits behind the register read stage of a 32-bit load/store pipeline. It handles the instruction class that moves halfwords and signed data. It decodes the offset, which is either an 8-bit immediate split into two nibbles or an unshifted index register. From that offset it forms the memory address and the base-register writeback value. It also checks the encoding and prepares the store lanes.

One cycle after a request is accepted, the registered address, writeback, store byte enables and replicated store data are presented. In that same cycle, the memory word the caller presents is formatted into a 32-bit load result: a byte or halfword lane, zero- or sign-extended. Condition evaluation, register file access and bus handshaking belong to the surrounding pipeline.

Top module: `hsl_fmt`

Bit positions used below refer to `instr`:

| Bit(s) | Field |
|---|---|
| 27:25 | must be 000 |
| 24 | pre-index select |
| 23 | add-offset select |
| 22 | immediate select |
| 21 | writeback select |
| 20 | load select |
| 7, 4 | must both be 1 |
| 6 | signed select |
| 5 | halfword select |

## Requirements
- R1: With `instr[22]`=1 the offset is the unsigned byte count {instr[11:8], instr[3:0]}, covering 0 to 255.
- R2: With `instr[22]`=0 the offset is the full `roff` value, unshifted; `instr[11:8]` must then be zero, otherwise the request is illegal.
- R3: The offset is added to `base` when `instr[23]`=1 and subtracted when 0. `addr` is that sum when `instr[24]`=1 (pre-index) and the unmodified `base` when `instr[24]`=0 (post-index).
- R4: `wb_data` is always `base` plus or minus the offset. `wb_en` is set in the result cycle when the request is neither illegal nor misaligned, and either it is post-indexed or `instr[21]`=1.
- R5: For a load, the field {instr[6], instr[5]} selects the format. 10 means a signed byte from lane `addr[1:0]`. 01 means a zero-extended halfword from lane `addr[1]`. 11 means a sign-extended halfword from lane `addr[1]`. Lanes are little-endian, with lane 0 at bits 7:0.
- R6: A halfword access (`instr[5]`=1) with `addr[0]`=1 on an otherwise legal request raises `misalign`. It also forces `wb_en`=0, `st_be`=0 and `ld_data`=0.
- R7: A legal store (`instr[20]`=0) asserts `st_be`=0011 when `addr[1]`=0 and 1100 when `addr[1]`=1. `st_data` always carries `st_src[15:0]` in both halves.
- R8: `illegal` is raised when any of these holds: `instr[27:25]`≠0, `instr[7]`=0, `instr[4]`=0, {instr[6], instr[5]}=00, a store with `instr[6]`=1, or R2's nonzero-nibble case. An illegal request gives `wb_en`=0, `st_be`=0, `ld_data`=0 and `misalign`=0.
- R9: `out_vld` is high exactly in the cycle after `in_vld`. Outside that cycle, `st_be` and `wb_en` are 0 and `addr` holds its last value. After reset, `out_vld`, `addr`, `st_be`, `wb_en`, `misalign` and `illegal` are 0.
- R10: `ld_data` is formed from the `mem_rdata` present during the result cycle. It is 0 for stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | Request strobe; clock enable for the result registers |
| instr | input | 32 | Instruction word |
| base | input | XLEN | Base register value |
| roff | input | XLEN | Index register value for the register-offset form |
| st_src | input | XLEN | Register value to be stored |
| mem_rdata | input | XLEN | Memory word read at `addr`, given in the result cycle |
| out_vld | output | 1 | Result cycle marker |
| addr | output | XLEN | Access address |
| wb_en | output | 1 | Base writeback enable |
| wb_data | output | XLEN | Updated base value |
| ld_data | output | XLEN | Formatted load result |
| st_be | output | XLEN/8 | Store byte enables |
| st_data | output | XLEN | Store data, halfword replicated |
| misalign | output | 1 | Halfword at an odd address |
| illegal | output | 1 | Rejected encoding |

## Verification
The bench builds the block at its default width of 32 bits, so there are four byte lanes and two halfword lanes. A nested sweep covers every combination of pre/post, up/down, immediate/register, writeback and load/store, across all four data-type codes. Each combination is run against four bases and four offsets, which reach every byte lane, both halfword lanes, odd-address faults, address wrap-around and both sign polarities in the memory word. Dedicated cases break each fixed bit of the encoding and check that the strobes return to zero between results.

// File: rtl/hsl_pkg.sv
package hsl_pkg;
  localparam int unsigned INSTR_W = 32;

  typedef enum logic [1:0] {
    DK_RSVD  = 2'b00,
    DK_UHALF = 2'b01,
    DK_SBYTE = 2'b10,
    DK_SHALF = 2'b11
  } dkind_e;

  typedef struct packed {
    logic   pre;
    logic   up;
    logic   wbk;
    logic   load;
    dkind_e kind;
  } hsl_ctl_t;
endpackage

// File: rtl/hsl_decode.sv
module hsl_decode
  import hsl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [XLEN-1:0]    roff,
  output hsl_ctl_t           ctl,
  output logic [XLEN-1:0]    off,
  output logic               bad
);
  logic       imm_sel;
  logic [7:0] imm8;

  always_comb begin
    imm_sel  = instr[22];
    imm8     = {instr[11:8], instr[3:0]};
    ctl.pre  = instr[24];
    ctl.up   = instr[23];
    ctl.wbk  = instr[21];
    ctl.load = instr[20];
    ctl.kind = dkind_e'(instr[6:5]);
    off      = imm_sel ? XLEN'(imm8) : roff;
    bad      = (instr[27:25] != 3'b000) || !instr[7] || !instr[4]
            || (instr[6:5] == 2'b00) || (!instr[20] && instr[6])
            || (!imm_sel && (instr[11:8] != 4'h0));
  end
endmodule

// File: rtl/hsl_agen.sv
module hsl_agen #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] off,
  input  logic            pre,
  input  logic            up,
  output logic [XLEN-1:0] addr,
  output logic [XLEN-1:0] upd
);
  always_comb begin
    upd  = up ? (base + off) : (base - off);
    addr = pre ? upd : base;
  end
endmodule

// File: rtl/hsl_stlane.sv
module hsl_stlane #(
  parameter int unsigned XLEN = 32
) (
  input  logic [$clog2(XLEN/8)-1:0] lane,
  input  logic [XLEN-1:0]           src,
  output logic [XLEN/8-1:0]         be_half,
  output logic [XLEN-1:0]           data
);
  localparam int unsigned NB     = XLEN / 8;
  localparam int unsigned LANE_W = $clog2(NB);
  localparam int unsigned NHALF  = XLEN / 16;

  for (genvar g = 0; g < NHALF; g++) begin : g_rep
    assign data[g*16 +: 16] = src[15:0];
  end

  assign be_half = NB'(3) << {lane[LANE_W-1:1], 1'b0};
endmodule

// File: rtl/hsl_ldext.sv
module hsl_ldext
  import hsl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]           word,
  input  logic [$clog2(XLEN/8)-1:0] lane,
  input  dkind_e                    kind,
  input  logic                      en,
  output logic [XLEN-1:0]           res
);
  localparam int unsigned LANE_W = $clog2(XLEN/8);

  logic [XLEN-1:0] byte_sh;
  logic [XLEN-1:0] half_sh;
  logic [7:0]      b8;
  logic [15:0]     h16;

  always_comb begin
    byte_sh = word >> {lane, 3'b000};
    half_sh = word >> {lane[LANE_W-1:1], 4'b0000};
    b8      = byte_sh[7:0];
    h16     = half_sh[15:0];
    res     = '0;
    if (en) begin
      unique case (kind)
        DK_SBYTE: res = {{(XLEN-8){b8[7]}}, b8};
        DK_UHALF: res = {{(XLEN-16){1'b0}}, h16};
        DK_SHALF: res = {{(XLEN-16){h16[15]}}, h16};
        default:  res = '0;
      endcase
    end
  end
endmodule

// File: rtl/hsl_fmt.sv
module hsl_fmt
  import hsl_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_vld,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [XLEN-1:0]     base,
  input  logic [XLEN-1:0]     roff,
  input  logic [XLEN-1:0]     st_src,
  input  logic [XLEN-1:0]     mem_rdata,
  output logic                out_vld,
  output logic [XLEN-1:0]     addr,
  output logic                wb_en,
  output logic [XLEN-1:0]     wb_data,
  output logic [XLEN-1:0]     ld_data,
  output logic [XLEN/8-1:0]   st_be,
  output logic [XLEN-1:0]     st_data,
  output logic                misalign,
  output logic                illegal
);
  localparam int unsigned NB     = XLEN / 8;
  localparam int unsigned LANE_W = $clog2(NB);

  hsl_ctl_t        ctl;
  logic [XLEN-1:0] off;
  logic            bad;
  logic [XLEN-1:0] addr_n, upd_n, std_n;
  logic [NB-1:0]   beh_n;

  logic            mis_n, fault_n, wben_n, ldk_n;
  logic [NB-1:0]   be_n;

  logic            vld_q, wben_q, mis_q, ill_q, ldk_q;
  logic [XLEN-1:0] addr_q, upd_q, std_q;
  logic [NB-1:0]   be_q;
  dkind_e          kind_q;

  hsl_decode #(.XLEN(XLEN)) u_dec (
    .instr (instr), .roff (roff), .ctl (ctl), .off (off), .bad (bad)
  );

  hsl_agen #(.XLEN(XLEN)) u_agen (
    .base (base), .off (off), .pre (ctl.pre), .up (ctl.up),
    .addr (addr_n), .upd (upd_n)
  );

  hsl_stlane #(.XLEN(XLEN)) u_st (
    .lane (addr_n[LANE_W-1:0]), .src (st_src), .be_half (beh_n), .data (std_n)
  );

  // next-state
  always_comb begin
    mis_n   = !bad && ctl.kind[0] && addr_n[0];
    fault_n = bad || mis_n;
    wben_n  = !fault_n && (ctl.pre ? ctl.wbk : 1'b1);
    be_n    = (!fault_n && !ctl.load) ? beh_n : '0;
    ldk_n   = !fault_n && ctl.load;
  end

  // registers, clock-enabled by in_vld
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      wben_q <= 1'b0;
      mis_q  <= 1'b0;
      ill_q  <= 1'b0;
      ldk_q  <= 1'b0;
      addr_q <= '0;
      upd_q  <= '0;
      std_q  <= '0;
      be_q   <= '0;
      kind_q <= DK_RSVD;
    end else begin
      vld_q <= in_vld;
      if (in_vld) begin
        wben_q <= wben_n;
        mis_q  <= mis_n;
        ill_q  <= bad;
        ldk_q  <= ldk_n;
        addr_q <= addr_n;
        upd_q  <= upd_n;
        std_q  <= std_n;
        be_q   <= be_n;
        kind_q <= ctl.kind;
      end
    end
  end

  hsl_ldext #(.XLEN(XLEN)) u_ld (
    .word (mem_rdata), .lane (addr_q[LANE_W-1:0]), .kind (kind_q),
    .en (ldk_q), .res (ld_data)
  );

  assign out_vld  = vld_q;
  assign addr     = addr_q;
  assign wb_en    = wben_q & vld_q;
  assign wb_data  = upd_q;
  assign st_be    = vld_q ? be_q : '0;
  assign st_data  = std_q;
  assign misalign = mis_q;
  assign illegal  = ill_q;
endmodule

// File: rtl/hsl_fmt_chk.sv
module hsl_fmt_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic              out_vld,
  input logic [XLEN-1:0]   addr,
  input logic              wb_en,
  input logic [XLEN-1:0]   ld_data,
  input logic [XLEN/8-1:0] st_be,
  input logic              misalign,
  input logic              illegal
);
  p_vld_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  p_vld_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> (!out_vld && st_be == '0 && !wb_en));
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(addr));
  p_misalign_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (st_be == '0 && !wb_en && ld_data == '0));
  p_illegal_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (st_be == '0 && !wb_en && ld_data == '0 && !misalign));
  p_be_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(st_be) == 0 || $countones(st_be) == 2));
  p_store_noload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_be != '0) |-> (ld_data == '0));
endmodule

bind hsl_fmt hsl_fmt_chk #(.XLEN(XLEN)) u_chk (
  .clk (clk), .rst_n (rst_n), .in_vld (in_vld), .out_vld (out_vld),
  .addr (addr), .wb_en (wb_en), .ld_data (ld_data), .st_be (st_be),
  .misalign (misalign), .illegal (illegal)
);

// File: tb/tb_hsl_fmt.sv
`timescale 1ns/1ps
module tb_hsl_fmt;
  localparam int unsigned XLEN = 32;

  logic        clk = 1'b0;
  logic        rst_n, in_vld;
  logic [31:0] instr, base, roff, st_src, mem_rdata;
  logic        out_vld, wb_en, misalign, illegal;
  logic [31:0] addr, wb_data, ld_data, st_data;
  logic [3:0]  st_be;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hsl_fmt #(.XLEN(XLEN)) dut (
    .clk (clk), .rst_n (rst_n), .in_vld (in_vld), .instr (instr), .base (base),
    .roff (roff), .st_src (st_src), .mem_rdata (mem_rdata), .out_vld (out_vld),
    .addr (addr), .wb_en (wb_en), .wb_data (wb_data), .ld_data (ld_data),
    .st_be (st_be), .st_data (st_data), .misalign (misalign), .illegal (illegal)
  );

  task automatic chk(input string rq, input string nm, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, nm, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit p, u, i, w, l, s, h,
                                     input logic [7:0] o8);
    return {4'hE, 3'b000, p, u, i, w, l, 4'h3, 4'h5, o8[7:4], 1'b1, s, h, 1'b1, o8[3:0]};
  endfunction

  // One request, expected results computed from the encoding (R1..R10)
  task automatic run(input logic [31:0] ins, input logic [31:0] b, input logic [31:0] r,
                     input logic [31:0] src, input logic [31:0] rd);
    logic [31:0] off, sum, ea, e_ld;
    logic [7:0]  by;
    logic [15:0] hw;
    bit bad, mis, flt, e_wb;
    logic [3:0] e_be;
    logic [31:0] prev;
    off  = ins[22] ? {24'h0, ins[11:8], ins[3:0]} : r;   // R1 / R2
    sum  = ins[23] ? b + off : b - off;                  // R3
    ea   = ins[24] ? sum : b;
    bad  = (ins[27:25] != 0) || !ins[7] || !ins[4] || (ins[6:5] == 2'b00)
        || (!ins[20] && ins[6]) || (!ins[22] && ins[11:8] != 0);
    mis  = !bad && ins[5] && ea[0];
    flt  = bad || mis;
    e_wb = !flt && (ins[24] ? ins[21] : 1'b1);
    e_be = (!flt && !ins[20]) ? (ea[1] ? 4'b1100 : 4'b0011) : 4'b0000;
    by   = rd[8*ea[1:0] +: 8];
    hw   = ea[1] ? rd[31:16] : rd[15:0];
    e_ld = 32'h0;
    if (!flt && ins[20]) begin
      case (ins[6:5])
        2'b10: e_ld = {{24{by[7]}}, by};
        2'b01: e_ld = {16'h0, hw};
        2'b11: e_ld = {{16{hw[15]}}, hw};
        default: e_ld = 32'h0;
      endcase
    end
    @(negedge clk);
    instr = ins; base = b; roff = r; st_src = src; in_vld = 1'b1;
    mem_rdata = 32'hDEAD_BEEF;
    @(negedge clk);
    in_vld = 1'b0; mem_rdata = rd;
    instr = 32'h0; base = 32'h0; roff = 32'h0;
    #1;
    chk("R9", "out_vld", {31'h0, out_vld}, 32'h1);
    chk(ins[22] ? "R1" : "R2", "addr", addr, ea);   // R3 pre/post
    chk("R4", "wb_data", wb_data, sum);
    chk("R4", "wb_en", {31'h0, wb_en}, {31'h0, e_wb});
    chk("R7", "st_be", {28'h0, st_be}, {28'h0, e_be});
    chk("R7", "st_data", st_data, {src[15:0], src[15:0]});
    chk(ins[20] ? "R5" : "R10", "ld_data", ld_data, e_ld);
    chk("R6", "misalign", {31'h0, misalign}, {31'h0, mis});
    chk("R8", "illegal", {31'h0, illegal}, {31'h0, bad});
    prev = addr;
    @(negedge clk); #1;
    chk("R9", "idle out_vld", {31'h0, out_vld}, 32'h0);
    chk("R9", "idle st_be", {28'h0, st_be}, 32'h0);
    chk("R9", "idle wb_en", {31'h0, wb_en}, 32'h0);
    chk("R9", "idle addr", addr, prev);
  endtask

  initial begin
    logic [31:0] bases [4];
    logic [7:0]  imms  [4];
    logic [31:0] regs  [4];
    logic [31:0] words [2];
    bases = '{32'h0000_0200, 32'h0000_1001, 32'h0000_FFFE, 32'h8000_0003};
    imms  = '{8'h00, 8'h0C, 8'hFF, 8'h81};
    regs  = '{32'h0, 32'h0000_000C, 32'h0000_0105, 32'hFFFF_FFF0};
    words = '{32'h80FF_7F01, 32'h7F01_80FE};
    rst_n = 1'b0; in_vld = 1'b0; instr = '0; base = '0; roff = '0;
    st_src = '0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R9 reset state
    chk("R9", "reset out_vld", {31'h0, out_vld}, 32'h0);
    chk("R9", "reset addr", addr, 32'h0);
    chk("R9", "reset st_be", {28'h0, st_be}, 32'h0);
    chk("R9", "reset wb_en", {31'h0, wb_en}, 32'h0);
    chk("R9", "reset flags", {30'h0, misalign, illegal}, 32'h0);
    // Sweep: R1 R2 R3 R4 R5 R6 R7 R8 R10
    for (int m = 0; m < 32; m++) begin
      for (int sh = 0; sh < 4; sh++) begin
        for (int bi = 0; bi < 4; bi++) begin
          for (int oi = 0; oi < 4; oi++) begin
            bit i;
            i = m[2];
            run(mk(m[4], m[3], i, m[1], m[0], sh[1], sh[0], i ? imms[oi] : 8'h00),
                bases[bi], regs[oi], 32'hA5C3_9E17 + 32'(bi), words[(bi + oi) % 2]);
          end
        end
      end
    end
    // R8 fixed-bit violations and R2 nibble rule
    run(mk(1, 1, 1, 0, 1, 1, 1, 8'h02) | 32'h0200_0000, 32'h100, 0, 0, words[0]);
    run(mk(1, 1, 1, 0, 1, 1, 1, 8'h02) & ~32'h0000_0080, 32'h100, 0, 0, words[0]);
    run(mk(1, 1, 1, 0, 1, 1, 1, 8'h02) & ~32'h0000_0010, 32'h100, 0, 0, words[0]);
    run(mk(1, 1, 0, 1, 1, 0, 1, 8'h40), 32'h100, 32'h4, 0, words[1]);
    run(mk(0, 1, 1, 0, 0, 1, 0, 8'h10), 32'h100, 0, 32'h1234, words[1]);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule